// File: doc/BRIEF.md
# Pin Direction Prober

This block characterises an unknown programmable logic device that has some dedicated inputs and a group of bidirectional pins. It holds one sweep counter. The low part of the counter drives each bidirectional pin weakly, one bit per pin, through an external series resistor. The high part drives the dedicated inputs. A single start pulse walks the counter once through every value. At each value the block waits a programmable number of clocks and then samples the bidirectional pins. Each sampled word is sent out on a valid/ready stream together with the counter value that produced it. The stream is the device's truth table.

While the sweep runs, each pin judge keeps two facts about its pin: whether the readback ever disagreed with the weak drive bit, and whether the readback was ever low. A pin that follows its weak drive on every step is an input. A pin that breaks away from it on some step is an output, because it is actively driven. A pin that never reads low is reported as stuck. This can happen because a strong internal pull-up on the device hides the weak drive, so that pin cannot be judged. The direction map is updated once, when the sweep ends.

Top module: `pin_dir_prober`

## Requirements
- R1: After reset, `busy`, `done` and `cap_valid` are 0, `cap_data` is 0 and every two-bit field of `dir_map` is 00 (not yet judged).
- R2: One sweep applies every counter value from 0 to 2^(N_ADDR+N_PIN)-1 in increasing order, exactly once each. `drv_weak` carries counter bits [N_PIN-1:0], where bit p weakly drives pin p. `drv_addr` carries the upper counter bits.
- R3: The pins are sampled only after the drive outputs have held a new value for at least `settle_cycles`+1 clock edges. A device whose readback trails the drive by up to `settle_cycles` registers is therefore captured correctly.
- R4: Each counter value produces exactly one stream word, with `cap_step` set to that counter value and `cap_data` set to the sampled pins. While `cap_valid` is high and `cap_ready` is low, `cap_step` and `cap_data` hold still and the drive does not advance.
- R5: A pin whose readback equals its weak drive bit on every step, and which reads low on some step, is reported in `dir_map[2p+1:2p]` as 01 (input).
- R6: A pin whose readback differs from its weak drive bit on at least one step, and which reads low on some step, is reported as 10 (output).
- R7: A pin that reads high on every step is reported as 11 (stuck/indeterminate). This code takes precedence over 01 and 10.
- R8: `busy` is high from the clock after an accepted start until the last word is accepted. At that same edge `done` rises and `dir_map` takes the new result. `done` stays high, and `dir_map` keeps its value, until the next sweep is started and then finished.
- R9: A start pulse that arrives while a sweep is running is ignored. The counter sequence and the word count are not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a sweep when the block is idle |
| settle_cycles | input | SETTLE_W | Extra wait clocks before each sample |
| drv_weak | output | N_PIN | Weak drive bits, one per bidirectional pin |
| drv_addr | output | N_ADDR | Drive for the device's dedicated inputs |
| pin_rd | input | N_PIN | Readback of the bidirectional pins |
| cap_valid | output | 1 | A captured word is waiting |
| cap_ready | input | 1 | The consumer takes the word |
| cap_step | output | N_ADDR+N_PIN | Counter value of the captured word |
| cap_data | output | N_PIN | Captured pin word |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Last sweep complete |
| dir_map | output | 2*N_PIN | Per-pin verdict: 00 none, 01 input, 10 output, 11 stuck |

## Verification
The bench models a device whose readback lags the drive by two registers. It runs the sweep with the wait set exactly at that lag. A sampler that is one clock early would therefore log the previous step's word in every row. Two device personalities cover the classification corners:
- an input pin that tracks its drive;
- an output that copies the drive on half the steps but not the other half, which a rule of "mostly matches" would misjudge;
- an output that always reads the inverse of its drive;
- an output that is always low;
- a pin held high throughout, which a design without the precedence rule would report as an output.

Ready is pulled low on a fixed pattern to expose a design that advances or changes the word under backpressure. A start pulse is injected mid-sweep to catch a design that restarts its counter.

// File: rtl/pdp_pkg.sv
package pdp_pkg;

  typedef enum logic [1:0] {
    DIR_NONE  = 2'b00,
    DIR_IN    = 2'b01,
    DIR_OUT   = 2'b10,
    DIR_STUCK = 2'b11
  } dir_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_SETTLE = 2'b01,
    ST_EMIT   = 2'b10
  } seq_st_e;

endpackage

// File: rtl/pdp_sweeper.sv
module pdp_sweeper
  import pdp_pkg::*;
#(
  parameter int STEP_W   = 16,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                ack,
  output logic [STEP_W-1:0]   step,
  output logic                sample_en,
  output logic                clear_en,
  output logic                finish,
  output logic                word_valid,
  output logic                busy
);

  localparam logic [STEP_W-1:0] LAST_STEP = '1;

  seq_st_e             st;
  logic [SETTLE_W-1:0] wait_q;

  assign clear_en   = (st == ST_IDLE) && start;
  assign sample_en  = (st == ST_SETTLE) && (wait_q == '0);
  assign word_valid = (st == ST_EMIT);
  assign finish     = word_valid && ack && (step == LAST_STEP);
  assign busy       = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      step   <= '0;
      wait_q <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            step   <= '0;
            wait_q <= settle_cycles;
            st     <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (wait_q == '0) st <= ST_EMIT;
          else              wait_q <= wait_q - 1'b1;
        end
        ST_EMIT: begin
          if (ack) begin
            if (step == LAST_STEP) begin
              st <= ST_IDLE;
            end else begin
              step   <= step + 1'b1;
              wait_q <= settle_cycles;
              st     <= ST_SETTLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pdp_pin_judge.sv
module pdp_pin_judge
  import pdp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic sample,
  input  logic drive,
  input  logic readback,
  input  logic publish,
  output dir_e verdict
);

  logic ever_diff;
  logic ever_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      ever_diff <= 1'b0;
      ever_low  <= 1'b0;
      verdict   <= DIR_NONE;
    end else begin
      if (clear) begin
        ever_diff <= 1'b0;
        ever_low  <= 1'b0;
      end else if (sample) begin
        if (readback != drive) ever_diff <= 1'b1;
        if (!readback)         ever_low  <= 1'b1;
      end
      if (publish) begin
        if (!ever_low)      verdict <= DIR_STUCK;
        else if (ever_diff) verdict <= DIR_OUT;
        else                verdict <= DIR_IN;
      end
    end
  end

endmodule

// File: rtl/pin_dir_prober.sv
module pin_dir_prober
  import pdp_pkg::*;
#(
  parameter int N_ADDR   = 8,
  parameter int N_PIN    = 8,
  parameter int SETTLE_W = 8,
  localparam int STEP_W  = N_ADDR + N_PIN
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic [N_PIN-1:0]    drv_weak,
  output logic [N_ADDR-1:0]   drv_addr,
  input  logic [N_PIN-1:0]    pin_rd,
  output logic                cap_valid,
  input  logic                cap_ready,
  output logic [STEP_W-1:0]   cap_step,
  output logic [N_PIN-1:0]    cap_data,
  output logic                busy,
  output logic                done,
  output logic [2*N_PIN-1:0]  dir_map
);

  logic [STEP_W-1:0] step;
  logic              sample_en;
  logic              clear_en;
  logic              finish;

  pdp_sweeper #(
    .STEP_W  (STEP_W),
    .SETTLE_W(SETTLE_W)
  ) u_sweeper (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .settle_cycles(settle_cycles),
    .ack          (cap_ready),
    .step         (step),
    .sample_en    (sample_en),
    .clear_en     (clear_en),
    .finish       (finish),
    .word_valid   (cap_valid),
    .busy         (busy)
  );

  assign drv_weak = step[N_PIN-1:0];
  assign drv_addr = step[STEP_W-1:N_PIN];
  assign cap_step = step;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_data <= '0;
      done     <= 1'b0;
    end else begin
      if (sample_en) cap_data <= pin_rd;
      if (clear_en)    done <= 1'b0;
      else if (finish) done <= 1'b1;
    end
  end

  dir_e verdicts [N_PIN];

  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    pdp_pin_judge u_judge (
      .clk     (clk),
      .rst     (rst),
      .clear   (clear_en),
      .sample  (sample_en),
      .drive   (step[p]),
      .readback(pin_rd[p]),
      .publish (finish),
      .verdict (verdicts[p])
    );
    assign dir_map[2*p +: 2] = verdicts[p];
  end

endmodule

// File: rtl/pdp_prober_chk.sv
module pdp_prober_chk #(
  parameter int N_ADDR   = 8,
  parameter int N_PIN    = 8,
  parameter int SETTLE_W = 8,
  localparam int STEP_W  = N_ADDR + N_PIN
) (
  input logic                clk,
  input logic                rst,
  input logic [SETTLE_W-1:0] settle_cycles,
  input logic [N_PIN-1:0]    drv_weak,
  input logic [N_ADDR-1:0]   drv_addr,
  input logic                cap_valid,
  input logic                cap_ready,
  input logic [STEP_W-1:0]   cap_step,
  input logic [N_PIN-1:0]    cap_data,
  input logic                busy,
  input logic                done,
  input logic [2*N_PIN-1:0]  dir_map
);

  localparam logic [SETTLE_W:0] SINCE_MAX = '1;

  logic [STEP_W-1:0] prev_drv;
  logic [SETTLE_W:0] since_chg;

  // Clocks elapsed since the drive outputs last changed (saturating).
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_drv  <= '0;
      since_chg <= SINCE_MAX;
    end else begin
      prev_drv <= {drv_addr, drv_weak};
      if ({drv_addr, drv_weak} != prev_drv) since_chg <= '0;
      else if (since_chg != SINCE_MAX)      since_chg <= since_chg + 1'b1;
    end
  end

  a_r4_hold_word: assert property (@(posedge clk) disable iff (rst)
    cap_valid && !cap_ready |=> cap_valid && $stable(cap_data) && $stable(cap_step));

  a_r4_valid_in_sweep: assert property (@(posedge clk) disable iff (rst)
    cap_valid |-> busy);

  a_r2_drive_tracks_word: assert property (@(posedge clk) disable iff (rst)
    cap_valid |-> ({drv_addr, drv_weak} == cap_step));

  a_r2_done_at_last: assert property (@(posedge clk) disable iff (rst)
    done |-> (&cap_step));

  a_r3_settled: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_valid) |-> (since_chg >= {1'b0, settle_cycles}));

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r8_map_frozen: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(dir_map));

endmodule

bind pin_dir_prober pdp_prober_chk #(
  .N_ADDR  (N_ADDR),
  .N_PIN   (N_PIN),
  .SETTLE_W(SETTLE_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .settle_cycles(settle_cycles),
  .drv_weak     (drv_weak),
  .drv_addr     (drv_addr),
  .cap_valid    (cap_valid),
  .cap_ready    (cap_ready),
  .cap_step     (cap_step),
  .cap_data     (cap_data),
  .busy         (busy),
  .done         (done),
  .dir_map      (dir_map)
);

// File: tb/pin_dir_prober_bench.sv
module pin_dir_prober_bench;

  localparam int NA = 2;
  localparam int NP = 4;
  localparam int SW = 3;
  localparam int STW = NA + NP;
  localparam int NSTEPS = 1 << STW;

  logic            clk = 1'b0;
  logic            rst;
  logic            start;
  logic [SW-1:0]   settle_cycles;
  logic [NP-1:0]   drv_weak;
  logic [NA-1:0]   drv_addr;
  logic [NP-1:0]   pin_rd;
  logic            cap_valid;
  logic            cap_ready;
  logic [STW-1:0]  cap_step;
  logic [NP-1:0]   cap_data;
  logic            busy;
  logic            done;
  logic [2*NP-1:0] dir_map;

  int checks = 0;
  int fails  = 0;
  int mode   = 0;

  always #10 clk = ~clk;

  pin_dir_prober #(.N_ADDR(NA), .N_PIN(NP), .SETTLE_W(SW)) u_pin_dir_prober (
    .clk(clk), .rst(rst), .start(start), .settle_cycles(settle_cycles),
    .drv_weak(drv_weak), .drv_addr(drv_addr), .pin_rd(pin_rd),
    .cap_valid(cap_valid), .cap_ready(cap_ready), .cap_step(cap_step),
    .cap_data(cap_data), .busy(busy), .done(done), .dir_map(dir_map)
  );

  // Device model: readback for a counter value, per personality.
  function automatic logic [NP-1:0] dev(input int md, input logic [STW-1:0] s);
    logic [NP-1:0] w;
    logic [NA-1:0] a;
    logic [NP-1:0] r;
    w = s[NP-1:0];
    a = s[STW-1:NP];
    if (md == 0) r = {w[3], 1'b1, a[0] ^ w[0], w[0]};
    else         r = {1'b0, 1'b1, a[0] ^ w[0], ~w[0]};
    return r;
  endfunction

  // Two-register device latency.
  logic [NP-1:0] q1 = '0;
  logic [NP-1:0] q2 = '0;
  always @(posedge clk) begin
    q1 <= dev(mode, {drv_addr, drv_weak});
    q2 <= q1;
  end
  assign pin_rd = q2;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input int md, input int st, input bit poke,
                     input logic [2*NP-1:0] prev_map, input logic [2*NP-1:0] exp_map);
    int idx = 0;
    int rc = 0;
    bit hold_pending = 0;
    logic [NP-1:0]  held_d = '0;
    logic [STW-1:0] held_s = '0;
    mode = md;
    settle_cycles = SW'(st);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && done == 1'b0, "R8 busy/done after start", {busy, done}, 2'b10);
    while (!done) begin
      @(negedge clk);
      start = 1'b0;
      rc++;
      cap_ready = (rc % 3) != 0;
      if (hold_pending) begin
        check(cap_valid && cap_data == held_d && cap_step == held_s, "R4 word held",
              {cap_valid, cap_step, cap_data}, {1'b1, held_s, held_d});
        hold_pending = 0;
      end
      if (cap_valid) begin
        if (cap_ready) begin
          check(cap_step == STW'(idx), "R2 step order", cap_step, idx);
          check(cap_data == dev(md, STW'(idx)), "R3 captured word",
                cap_data, dev(md, STW'(idx)));
          idx++;
          if (poke && idx == 10) start = 1'b1;   // R9 mid-sweep start
          if (idx == 20) check(dir_map == prev_map, "R8 map held during sweep",
                               dir_map, prev_map);
        end else begin
          hold_pending = 1;
          held_d = cap_data;
          held_s = cap_step;
        end
      end
    end
    cap_ready = 1'b0;
    check(idx == NSTEPS, "R2 R9 word count", idx, NSTEPS);
    check(busy == 1'b0, "R8 idle at end", busy, 0);
    for (int p = 0; p < NP; p++) begin
      if (exp_map[2*p +: 2] == 2'b01)
        check(dir_map[2*p +: 2] == 2'b01, "R5 input pin", dir_map[2*p +: 2], 2'b01);
      else if (exp_map[2*p +: 2] == 2'b10)
        check(dir_map[2*p +: 2] == 2'b10, "R6 output pin", dir_map[2*p +: 2], 2'b10);
      else
        check(dir_map[2*p +: 2] == exp_map[2*p +: 2], "R7 stuck pin",
              dir_map[2*p +: 2], exp_map[2*p +: 2]);
    end
    repeat (3) @(negedge clk);
    check(done == 1'b1 && dir_map == exp_map, "R8 result held", {done, dir_map},
          {1'b1, exp_map});
  endtask

  initial begin
    rst = 1'b1;
    start = 1'b0;
    cap_ready = 1'b0;
    settle_cycles = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(busy == 0 && done == 0 && cap_valid == 0 && cap_data == '0 && dir_map == '0,
          "R1 reset state", {busy, done, cap_valid, cap_data, dir_map}, 0);
    rst = 1'b0;
    // pins 3..0: input, stuck, output, input
    run(0, 2, 1'b1, 8'b00_00_00_00, 8'b01_11_10_01);
    // pins 3..0: output, stuck, output, output
    run(1, 5, 1'b0, 8'b01_11_10_01, 8'b10_11_10_10);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule